// File: doc/BRIEF.md
# DMX In-Band Configuration Capture

This block sits beside a DMX slot receiver and watches the same stream of received slots. While its enable input is high after reset, it looks for a packet that carries new settings: a signature byte, a 9-bit base address split over two slots, and an 8-bit mode byte. The first packet with the correct signature and enough slots ends the capture. If its address is legal, the block loads the settings and pulses a done strobe. If the address is not legal, the block raises a sticky error flag instead.

The slot stream uses three strobes. `frameStart` opens a packet. Each `slotValid` cycle then delivers the next data slot, starting at slot 1. `frameEnd` closes the packet and may fall in the same cycle as its last slot. The captured address and mode are held on the outputs until reset, where a persistent store can latch them. A switch-present input is sampled while reset is held. If it is set, the outputs show the switch values for the rest of the run and in-band capture stays off.

Top module: `cfg_inband_capture`

## Requirements
- R1: While reset is held and just after it is released (with switch-present low), `cfgDone` and `cfgError` are 0 and `baseAddr` and `modeByte` are 0.
- R2: A packet is accepted when slot 1 equals the signature (default 0xA5) and at least 4 slots arrived. With an address in range, `cfgDone` is high for exactly one cycle, the cycle after the clock edge that samples `frameEnd`. At that same time `baseAddr` becomes {slot 2 bit 0, slot 3} and `modeByte` becomes slot 4.
- R3: A packet whose slot 1 is not the signature causes no done and no error. The block keeps waiting, and a later correct packet is accepted.
- R4: A packet that ends with fewer than 4 slots is invalid: no done, no error, and the block keeps waiting.
- R5: Slots after slot 4 do not affect the captured values.
- R6: If an accepted packet's address is 0 or greater than `MAX_BASE` (default 509), `cfgError` rises in the cycle where done would have risen and stays high until reset. `cfgDone` stays low, `baseAddr` and `modeByte` stay 0, and capture ends.
- R7: After a done or an error, later packets cause no further done and leave `baseAddr` and `modeByte` unchanged.
- R8: Packets that end while `cfgEnable` is low are ignored.
- R9: If `switchPresent` is high while reset is held, `baseAddr` and `modeByte` show `swAddr` and `swMode` and `cfgDone` never rises.
- R10: A slot delivered in the same cycle as `frameEnd` counts as part of the packet.
- R11: Only bit 0 of slot 2 is used; bits 7 to 1 of slot 2 have no effect on `baseAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Configuration capture enable |
| switchPresent | input | 1 | Switch settings take priority (sampled in reset) |
| swAddr | input | 9 | Switch base address |
| swMode | input | 8 | Switch mode byte |
| frameStart | input | 1 | Opens a new packet |
| slotValid | input | 1 | A data slot is on `slotData` |
| slotData | input | 8 | Slot value |
| frameEnd | input | 1 | Closes the current packet |
| cfgDone | output | 1 | One-cycle pulse on successful capture |
| cfgError | output | 1 | Sticky error on out-of-range address |
| baseAddr | output | 9 | Captured or switch base address |
| modeByte | output | 8 | Captured or switch mode byte |

## Verification
Two things can happen in one cycle. The final slot can arrive, and `frameEnd` can close the packet, so the length check, the signature check and the address check must all see the slot that is arriving in that cycle. Table vectors send each packet in two forms: one with `frameEnd` merged into the last slot's cycle, and one with `frameEnd` in a separate cycle afterwards. In both forms the done or error outcome and the captured address must match. A 4-slot packet with merged `frameEnd` is accepted only if the 4th slot is counted, which is how R10 is judged.

// File: rtl/cfgcap_pkg.sv
package cfgcap_pkg;
  typedef struct packed {
    logic loadCfg;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } capState_t;
endpackage

// File: rtl/cfgcap_datapath.sv
module cfgcap_datapath
  import cfgcap_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int MAX_BASE = 509,
  parameter logic [DATA_W-1:0] SIG = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              slotValid,
  input  logic [DATA_W-1:0] slotData,
  input  cfgStrobe_t        strb,
  input  logic              swSel,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [DATA_W-1:0] swMode,
  output logic              frameOk,
  output logic              addrInRange,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [DATA_W-1:0] modeByte
);
  localparam int NUM_FIELDS = 4;
  localparam int CNT_W      = $clog2(NUM_FIELDS + 2);
  localparam int CNT_SAT    = NUM_FIELDS + 1;
  localparam int HI_W       = ADDR_W - DATA_W;

  logic [CNT_W-1:0]  cntQ, cntBase, cntNext;
  logic [DATA_W-1:0] shadowQ   [NUM_FIELDS];
  logic [DATA_W-1:0] shadowNxt [NUM_FIELDS];
  logic [ADDR_W-1:0] candAddr, addrQ;
  logic [DATA_W-1:0] modeQ;

  always_comb begin
    cntBase = frameStart ? '0 : cntQ;
    cntNext = (slotValid && cntBase != CNT_W'(CNT_SAT)) ? cntBase + 1'b1 : cntBase;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntNext;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    assign shadowNxt[k] = (slotValid && cntBase == CNT_W'(k)) ? slotData : shadowQ[k];
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) shadowQ[k] <= '0;
      else       shadowQ[k] <= shadowNxt[k];
  end

  always_comb begin
    candAddr    = {shadowNxt[1][HI_W-1:0], shadowNxt[2]};
    frameOk     = (cntNext >= CNT_W'(NUM_FIELDS)) && (shadowNxt[0] == SIG);
    addrInRange = (candAddr != '0) && (candAddr <= ADDR_W'(MAX_BASE));
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      addrQ <= '0;
      modeQ <= '0;
    end else if (strb.loadCfg) begin
      addrQ <= candAddr;
      modeQ <= shadowNxt[3];
    end

  assign baseAddr = swSel ? swAddr : addrQ;
  assign modeByte = swSel ? swMode : modeQ;

  // R6: a load is only ever requested for a legal address
  a_r6_load_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCfg |-> addrInRange);
  // R5: slot counter saturates past the last field
  a_r5_cnt_sat: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(CNT_SAT));
  // R9: switch priority blocks any in-band load
  a_r9_no_load_sw: assert property (@(posedge clk) disable iff (!rstN)
    swSel |-> !strb.loadCfg);
endmodule

// File: rtl/cfgcap_control.sv
module cfgcap_control
  import cfgcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic       swSel,
  input  logic       frameEnd,
  input  logic       frameOk,
  input  logic       addrInRange,
  output cfgStrobe_t strb,
  output logic       cfgDone,
  output logic       cfgError
);
  capState_t state;
  logic accept;

  always_comb begin
    accept       = (state == ST_WAIT) && cfgEnable && !swSel && frameEnd && frameOk;
    strb.loadCfg = accept && addrInRange;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state    <= ST_WAIT;
      cfgDone  <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      cfgDone <= strb.loadCfg;
      if (accept && !addrInRange) cfgError <= 1'b1;
      if (accept) state <= addrInRange ? ST_DONE : ST_FAIL;
    end

  // R2/R7: done is a single pulse, never repeated once finished
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> !cfgDone);
  // R6: error is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);
  // R6: done and error are exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && cfgError));
  // R9: no done while switch values take priority
  a_r9_no_done_sw: assert property (@(posedge clk) disable iff (!rstN)
    swSel |-> !cfgDone);
endmodule

// File: rtl/cfg_inband_capture.sv
module cfg_inband_capture
  import cfgcap_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int MAX_BASE = 509,
  parameter logic [DATA_W-1:0] SIG = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              switchPresent,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [DATA_W-1:0] swMode,
  input  logic              frameStart,
  input  logic              slotValid,
  input  logic [DATA_W-1:0] slotData,
  input  logic              frameEnd,
  output logic              cfgDone,
  output logic              cfgError,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [DATA_W-1:0] modeByte
);
  cfgStrobe_t strb;
  logic swSel, frameOk, addrInRange;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) swSel <= switchPresent;
    else       swSel <= swSel;

  cfgcap_control u_ctrl (
    .clk, .rstN, .cfgEnable, .swSel, .frameEnd, .frameOk, .addrInRange,
    .strb, .cfgDone, .cfgError
  );

  cfgcap_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BASE(MAX_BASE), .SIG(SIG)
  ) u_dp (
    .clk, .rstN, .frameStart, .slotValid, .slotData, .strb, .swSel,
    .swAddr, .swMode, .frameOk, .addrInRange, .baseAddr, .modeByte
  );
endmodule

// File: tb/tb_cfg_inband_capture.sv
`timescale 1ns/1ps
module tb_cfg_inband_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b1, switchPresent = 1'b0;
  logic [8:0] swAddr = 9'h0AB;
  logic [7:0] swMode = 8'h5C;
  logic frameStart = 1'b0, slotValid = 1'b0, frameEnd = 1'b0;
  logic [7:0] slotData = '0;
  logic cfgDone, cfgError;
  logic [8:0] baseAddr;
  logic [7:0] modeByte;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_inband_capture dut (.*);

  // fields: sig, slot2, slot3, mode, len, merge, expect (0 none, 1 done, 2 error)
  localparam logic [55:0] VEC [10] = '{
    {8'hA5, 8'h01, 8'h23, 8'hC4, 8'd4, 8'd0, 8'd1},
    {8'hA5, 8'h01, 8'h23, 8'hC4, 8'd4, 8'd1, 8'd1},
    {8'hA5, 8'h00, 8'h01, 8'h00, 8'd4, 8'd1, 8'd1},
    {8'hA5, 8'h01, 8'hFD, 8'h7E, 8'd4, 8'd0, 8'd1},
    {8'hA5, 8'h01, 8'hFE, 8'h7E, 8'd4, 8'd1, 8'd2},
    {8'hA5, 8'h00, 8'h00, 8'h11, 8'd4, 8'd0, 8'd2},
    {8'h5A, 8'h00, 8'h22, 8'h11, 8'd4, 8'd0, 8'd0},
    {8'hA5, 8'h00, 8'h22, 8'h11, 8'd3, 8'd1, 8'd0},
    {8'hA5, 8'hFF, 8'h10, 8'h33, 8'd7, 8'd0, 8'd1},
    {8'hA5, 8'h02, 8'h10, 8'h44, 8'd4, 8'd1, 8'd1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(logic sw);
    rstN = 1'b0;
    switchPresent = sw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    switchPresent = 1'b0;
  endtask

  task automatic sendPkt(logic [7:0] s1, s2, s3, s4, int len, bit merge);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int i = 1; i <= len; i++) begin
      slotValid = 1'b1;
      slotData  = (i == 1) ? s1 : (i == 2) ? s2 : (i == 3) ? s3 : (i == 4) ? s4 : 8'(8'h40 + i);
      frameEnd  = merge && (i == len);
      @(negedge clk);
    end
    slotValid = 1'b0;
    frameEnd  = 1'b0;
    if (!merge) begin
      frameEnd = 1'b1;
      @(negedge clk);
      frameEnd = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 done in reset", cfgDone, 0);
    check("R1 addr in reset", baseAddr, 0);
    doReset(0);
    check("R1 done", cfgDone, 0);
    check("R1 error", cfgError, 0);
    check("R1 addr", baseAddr, 0);
    check("R1 mode", modeByte, 0);

    // table: R2 R4 R5 R6 R10 R11 R3
    for (int v = 0; v < 10; v++) begin
      logic [7:0] s1, s2, s3, s4, len, mg, ex;
      logic [8:0] eAddr;
      logic [7:0] eMode;
      {s1, s2, s3, s4, len, mg, ex} = VEC[v];
      eAddr = (ex == 1) ? {s2[0], s3} : 9'h0;
      eMode = (ex == 1) ? s4 : 8'h0;
      doReset(0);
      sendPkt(s1, s2, s3, s4, int'(len), mg[0]);
      check($sformatf("R2/R10 vec%0d done", v), cfgDone, (ex == 1));
      check($sformatf("R6/R3/R4 vec%0d error", v), cfgError, (ex == 2));
      check($sformatf("R2/R5/R11 vec%0d addr", v), baseAddr, eAddr);
      check($sformatf("R2/R5 vec%0d mode", v), modeByte, eMode);
      @(negedge clk);
      check($sformatf("R2 vec%0d pulse ends", v), cfgDone, 0);
      check($sformatf("R6 vec%0d error held", v), cfgError, (ex == 2));
    end

    // R3: bad signature then good packet is accepted
    doReset(0);
    sendPkt(8'h00, 8'h01, 8'h02, 8'h03, 4, 0);
    check("R3 no done on bad sig", cfgDone, 0);
    sendPkt(8'hA5, 8'h00, 8'h42, 8'h99, 4, 0);
    check("R3 later good done", cfgDone, 1);
    check("R3 later good addr", baseAddr, 9'h042);

    // R4: short then good
    doReset(0);
    sendPkt(8'hA5, 8'h00, 8'h42, 8'h99, 2, 0);
    check("R4 short no done", cfgDone, 0);
    sendPkt(8'hA5, 8'h01, 8'h07, 8'h66, 4, 1);
    check("R4 later done", cfgDone, 1);

    // R7: only first accepted packet counts
    doReset(0);
    sendPkt(8'hA5, 8'h00, 8'h55, 8'h12, 4, 0);
    check("R7 first done", cfgDone, 1);
    sendPkt(8'hA5, 8'h01, 8'h99, 8'h34, 4, 0);
    check("R7 second no done", cfgDone, 0);
    check("R7 addr held", baseAddr, 9'h055);
    check("R7 mode held", modeByte, 8'h12);

    // R7/R6: after error, a good packet is ignored
    doReset(0);
    sendPkt(8'hA5, 8'h01, 8'hFF, 8'h12, 4, 0);
    check("R6 error set", cfgError, 1);
    sendPkt(8'hA5, 8'h00, 8'h20, 8'h34, 4, 0);
    check("R7 no done after error", cfgDone, 0);
    check("R7 addr still 0 after error", baseAddr, 0);
    check("R6 error still set", cfgError, 1);

    // R8: disabled frames ignored
    doReset(0);
    cfgEnable = 1'b0;
    sendPkt(8'hA5, 8'h00, 8'h30, 8'h31, 4, 0);
    check("R8 no done when disabled", cfgDone, 0);
    check("R8 addr untouched", baseAddr, 0);
    cfgEnable = 1'b1;
    sendPkt(8'hA5, 8'h00, 8'h32, 8'h33, 4, 0);
    check("R8 done when enabled", cfgDone, 1);
    check("R8 addr", baseAddr, 9'h032);

    // R9: switch priority
    doReset(1);
    check("R9 switch addr", baseAddr, 9'h0AB);
    check("R9 switch mode", modeByte, 8'h5C);
    sendPkt(8'hA5, 8'h00, 8'h30, 8'h31, 4, 0);
    check("R9 no done", cfgDone, 0);
    check("R9 addr still switch", baseAddr, 9'h0AB);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule